// File: doc/BRIEF.md
# Cell Payload Prefix Match and Append

This block sits in a cell stream carried as 32-bit words, one word per clock, where a start-of-cell strobe marks the first word of each 14-word cell. Words 0 and 1 of a cell are header. The payload begins at word 2, and its first character is in the most significant byte. The block checks whether the payload opens with the five ASCII characters `HELLO`. When it does, the five payload bytes that follow the prefix are overwritten with `WORLD`. Every other cell, and every word outside a cell, passes through unchanged.

The prefix ends in the top byte of word 3, and the first appended characters fall in the low bytes of that same word. For this reason the block holds each word for two register stages. The decision is made on the first stage and applied as the word leaves the second stage. A small state machine follows each cell's progress. Cells may arrive back to back without a gap. A start-of-cell strobe that arrives before a cell is complete abandons that cell and starts a new one. The downstream cell-available flag is passed straight upstream.

Top module: `hello_append`

## Requirements
- R1: While reset is asserted, and until the first word has travelled through, `tx_soc` is 0 and `tx_data` is 0.
- R2: `tx_soc` and `tx_data` repeat `rx_soc` and `rx_data` exactly two clock cycles later, except for the rewritten bytes given in R3.
- R3: If word 2 of a cell equals 32'h48454C4C and bits [31:24] of word 3 equal 8'h4F, then bits [23:0] of word 3 leave as 24'h574F52 and bits [31:16] of word 4 leave as 16'h4C44. All other bits of those words are unchanged.
- R4: If any one of the five prefix bytes differs from the values in R3, the whole cell leaves unchanged.
- R5: Only words 3 and 4 of a cell (word 0 is the word that carries the strobe) can ever be modified. A `HELLO` pattern in header words, in later payload words, or in words outside a cell has no effect.
- R6: Back-to-back cells, with a strobe every 14 cycles and no idle words, are each judged on their own payload, and no decision carries over from the cell before.
- R7: A strobe in the middle of a cell ends that cell. The strobed word is treated as word 0 of a new cell, and no rewrite is applied to any word of the abandoned cell that had not yet reached its decision.
- R8: `rx_room` equals `tx_room` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_data | input | 32 | Incoming cell word |
| rx_soc | input | 1 | High on the first word of an incoming cell |
| rx_room | output | 1 | Cell-available flag returned to the upstream source |
| tx_data | output | 32 | Outgoing cell word, two cycles after input |
| tx_soc | output | 1 | High on the first word of an outgoing cell |
| tx_room | input | 1 | Cell-available flag from the downstream sink |

## Verification
The checker examines every cycle. It confirms that the strobe arrives two cycles after input, and that any byte differing from the delayed input lies in word 3 or word 4. It also confirms that those bytes carry exactly the appended characters, that a word-4 edit always follows a word-3 edit, and that a strobe returns the state machine to header capture. Only the bench's scenarios can show that near-miss prefixes leave the cell untouched, and that back-to-back and abandoned cells are each judged on their own words. The same holds for the reset value and for passing the cell-available flag through.

// File: rtl/hello_append_pkg.sv
package hello_append_pkg;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_HEAD,
    MS_PFX,
    MS_HIT,
    MS_PASS
  } match_st_t;

  localparam logic [31:0] PFX_WORD  = 32'h48454C4C;
  localparam logic [7:0]  PFX_LAST  = 8'h4F;
  localparam logic [23:0] APP_FIRST = 24'h574F52;
  localparam logic [15:0] APP_REST  = 16'h4C44;

endpackage

// File: rtl/cm_rst_sync.sv
module cm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_qn
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_qn = chain_q[STAGES-1];

endmodule

// File: rtl/cm_word_tracker.sv
module cm_word_tracker #(
  parameter int DATA_W     = 32,
  parameter int CELL_WORDS = 14,
  localparam int IDX_W     = $clog2(CELL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_qn,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_soc,
  output logic [DATA_W-1:0] s1_data,
  output logic              s1_soc,
  output logic              s1_act,
  output logic [IDX_W-1:0]  s1_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

  logic [IDX_W-1:0] idx_d;
  logic             act_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = rx_soc | s1_act;
    idx_d  = s1_idx;
    act_d  = s1_act;
    if (rx_soc) begin
      idx_d = '0;
      act_d = 1'b1;
    end else if (s1_act) begin
      if (s1_idx == LAST_IDX) begin
        act_d = 1'b0;
      end else begin
        idx_d = s1_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_qn) begin
    if (!rst_qn) begin
      s1_idx <= '0;
      s1_act <= 1'b0;
    end else if (cnt_en) begin
      s1_idx <= idx_d;
      s1_act <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_qn) begin
    if (!rst_qn) begin
      s1_data <= '0;
      s1_soc  <= 1'b0;
    end else begin
      s1_data <= rx_data;
      s1_soc  <= rx_soc;
    end
  end

endmodule

// File: rtl/cm_prefix_matcher.sv
module cm_prefix_matcher
  import hello_append_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 4,
  parameter int PAY_START = 2
) (
  input  logic              clk,
  input  logic              rst_qn,
  input  logic [DATA_W-1:0] s1_data,
  input  logic              s1_soc,
  input  logic              s1_act,
  input  logic [IDX_W-1:0]  s1_idx,
  output match_st_t         mstate,
  output logic              edit_first,
  output logic              edit_rest
);

  localparam logic [IDX_W-1:0] IDX_HEAD4 = IDX_W'(PAY_START);
  localparam logic [IDX_W-1:0] IDX_LAST1 = IDX_W'(PAY_START + 1);
  localparam logic [IDX_W-1:0] IDX_TAIL  = IDX_W'(PAY_START + 2);

  match_st_t st_d;
  logic      last_ok;

  always_comb begin
    last_ok = (s1_data[DATA_W-1 -: 8] == PFX_LAST);
  end

  always_comb begin
    st_d = mstate;
    if (s1_soc) begin
      st_d = MS_HEAD;
    end else if (!s1_act) begin
      st_d = MS_IDLE;
    end else begin
      if (s1_idx == IDX_HEAD4) begin
        st_d = (s1_data[31:0] == PFX_WORD) ? MS_PFX : MS_PASS;
      end else if (s1_idx == IDX_LAST1) begin
        st_d = (mstate == MS_PFX && last_ok) ? MS_HIT : MS_PASS;
      end else if (s1_idx == IDX_TAIL) begin
        st_d = MS_PASS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_qn) begin
    if (!rst_qn) begin
      mstate <= MS_IDLE;
    end else begin
      mstate <= st_d;
    end
  end

  always_comb begin
    edit_first = s1_act && !s1_soc && (s1_idx == IDX_LAST1) &&
                 (mstate == MS_PFX) && last_ok;
    edit_rest  = s1_act && !s1_soc && (s1_idx == IDX_TAIL) &&
                 (mstate == MS_HIT);
  end

endmodule

// File: rtl/cm_rewriter.sv
module cm_rewriter
  import hello_append_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_qn,
  input  logic [DATA_W-1:0] s1_data,
  input  logic              s1_soc,
  input  logic              edit_first,
  input  logic              edit_rest,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_soc
);

  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = s1_data;
    if (edit_first) begin
      data_d[23:0] = APP_FIRST;
    end else if (edit_rest) begin
      data_d[31:16] = APP_REST;
    end
  end

  always_ff @(posedge clk or negedge rst_qn) begin
    if (!rst_qn) begin
      tx_data <= '0;
      tx_soc  <= 1'b0;
    end else begin
      tx_data <= data_d;
      tx_soc  <= s1_soc;
    end
  end

endmodule

// File: rtl/hello_append.sv
module hello_append
  import hello_append_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int PAY_START  = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_soc,
  output logic              rx_room,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_soc,
  input  logic              tx_room
);

  localparam int IDX_W = $clog2(CELL_WORDS);

  logic              rst_qn;
  logic [DATA_W-1:0] s1_data;
  logic              s1_soc;
  logic              s1_act;
  logic [IDX_W-1:0]  s1_idx;
  match_st_t         mstate;
  logic              edit_first;
  logic              edit_rest;

  cm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_qn(rst_qn)
  );

  cm_word_tracker #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS)) u_track (
    .clk    (clk),
    .rst_qn (rst_qn),
    .rx_data(rx_data),
    .rx_soc (rx_soc),
    .s1_data(s1_data),
    .s1_soc (s1_soc),
    .s1_act (s1_act),
    .s1_idx (s1_idx)
  );

  cm_prefix_matcher #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PAY_START(PAY_START)) u_match (
    .clk       (clk),
    .rst_qn    (rst_qn),
    .s1_data   (s1_data),
    .s1_soc    (s1_soc),
    .s1_act    (s1_act),
    .s1_idx    (s1_idx),
    .mstate    (mstate),
    .edit_first(edit_first),
    .edit_rest (edit_rest)
  );

  cm_rewriter #(.DATA_W(DATA_W)) u_rew (
    .clk       (clk),
    .rst_qn    (rst_qn),
    .s1_data   (s1_data),
    .s1_soc    (s1_soc),
    .edit_first(edit_first),
    .edit_rest (edit_rest),
    .tx_data   (tx_data),
    .tx_soc    (tx_soc)
  );

  assign rx_room = tx_room;

endmodule

// File: rtl/hello_append_chk.sv
module hello_append_chk
  import hello_append_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 4,
  parameter int PAY_START = 2
) (
  input logic              clk,
  input logic              rst_qn,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_soc,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_soc,
  input logic [IDX_W-1:0]  s1_idx,
  input match_st_t         mstate
);

  localparam logic [IDX_W-1:0] IDX_W3 = IDX_W'(PAY_START + 1);
  localparam logic [IDX_W-1:0] IDX_W4 = IDX_W'(PAY_START + 2);

  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_qn) begin
    if (!rst_qn) begin
      warm <= '0;
    end else if (warm != 2'd2) begin
      warm <= warm + 1'b1;
    end
  end

  assert_soc_latency_R2: assert property (@(posedge clk) disable iff (!rst_qn)
    (warm == 2'd2) |-> (tx_soc == $past(rx_soc, 2)));

  assert_edit_confined_R5: assert property (@(posedge clk) disable iff (!rst_qn)
    (warm == 2'd2 && tx_data != $past(rx_data, 2)) |->
      ($past(s1_idx) == IDX_W3 || $past(s1_idx) == IDX_W4));

  assert_first_bytes_R3: assert property (@(posedge clk) disable iff (!rst_qn)
    (warm == 2'd2 && tx_data != $past(rx_data, 2) && $past(s1_idx) == IDX_W3) |->
      (tx_data[23:0] == APP_FIRST && tx_data[31:24] == $past(rx_data[31:24], 2)));

  assert_rest_bytes_R3: assert property (@(posedge clk) disable iff (!rst_qn)
    (warm == 2'd2 && tx_data != $past(rx_data, 2) && $past(s1_idx) == IDX_W4) |->
      (tx_data[31:16] == APP_REST && tx_data[15:0] == $past(rx_data[15:0], 2) &&
       $past(tx_data[23:0]) == APP_FIRST));

  assert_soc_restart_R7: assert property (@(posedge clk) disable iff (!rst_qn)
    rx_soc |=> ##1 (mstate == MS_HEAD));

endmodule

bind hello_append hello_append_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PAY_START(PAY_START)) u_chk (
  .clk    (clk),
  .rst_qn (rst_qn),
  .rx_data(rx_data),
  .rx_soc (rx_soc),
  .tx_data(tx_data),
  .tx_soc (tx_soc),
  .s1_idx (s1_idx),
  .mstate (mstate)
);

// File: tb/hello_append_test.sv
module hello_append_test;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 14;

  typedef logic [31:0] cell_t [NW];

  logic        clk;
  logic        rst_n;
  logic [31:0] rx_data;
  logic        rx_soc;
  logic        rx_room;
  logic [31:0] tx_data;
  logic        tx_soc;
  logic        tx_room;

  int total;
  int bad;
  int cyc;
  bit finished;

  logic [31:0] ex_d [256];
  logic        ex_s [256];
  bit          ex_v [256];
  string       ex_tag [256];

  hello_append uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_data(rx_data),
    .rx_soc (rx_soc),
    .rx_room(rx_room),
    .tx_data(tx_data),
    .tx_soc (tx_soc),
    .tx_room(tx_room)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] d, input logic [31:0] e, input logic s, input string tag);
    int slot;
    @(negedge clk);
    if (cyc >= 2) begin
      slot = (cyc - 2) % 256;
      if (ex_v[slot]) begin
        check(tx_soc == ex_s[slot], {ex_tag[slot], " soc"}, 32'(tx_soc), 32'(ex_s[slot]));
        check(tx_data == ex_d[slot], {ex_tag[slot], " data"}, tx_data, ex_d[slot]);
      end
    end
    slot = cyc % 256;
    rx_data = d;
    rx_soc = s;
    ex_d[slot] = e;
    ex_s[slot] = s;
    ex_v[slot] = 1'b1;
    ex_tag[slot] = tag;
    cyc++;
  endtask

  function automatic cell_t mk_cell(input int seed, input bit hello);
    cell_t w;
    for (int k = 0; k < NW; k++) begin
      w[k] = {8'(seed), 8'(k), ~8'(seed), 8'h5A};
    end
    w[0] = 32'hA000_0000 | 32'(seed);
    w[1] = 32'hB000_0000 | 32'(seed);
    if (hello) begin
      w[2] = 32'h48454C4C;
      w[3] = {8'h4F, 24'h112233};
    end
    return w;
  endfunction

  // Expected words derived from R3/R4: rewrite only on full five-byte prefix.
  task automatic send_cell(input cell_t w, input int nsend, input string tag);
    cell_t e;
    e = w;
    if (w[2] == 32'h48454C4C && w[3][31:24] == 8'h4F) begin
      e[3][23:0] = 24'h574F52;
      e[4][31:16] = 16'h4C44;
    end
    for (int k = 0; k < nsend; k++) begin
      step(w[k], e[k], k == 0, tag);
    end
  endtask

  task automatic idle(input int n, input logic [31:0] d, input string tag);
    for (int k = 0; k < n; k++) begin
      step(d, d, 1'b0, tag);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    rx_soc = 1'b1;
    rx_data = 32'hFFFF_FFFF;
    tx_room = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_soc == 1'b0, "R1 soc in reset", 32'(tx_soc), 32'h0);
    check(tx_data == 32'h0, "R1 data in reset", tx_data, 32'h0);
    rx_soc = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_soc == 1'b0, "R1 soc after release", 32'(tx_soc), 32'h0);
    check(tx_data == 32'h0, "R1 data after release", tx_data, 32'h0);
  endtask

  task automatic t_match;
    send_cell(mk_cell(1, 1'b1), NW, "R3 match");
    idle(3, 32'h0, "R2 idle");
  endtask

  task automatic t_near_miss;
    cell_t w;
    for (int b = 0; b < 5; b++) begin
      w = mk_cell(10 + b, 1'b1);
      if (b < 4) w[2][31 - 8*b -: 8] = w[2][31 - 8*b -: 8] ^ 8'h20;
      else w[3][31:24] = 8'h6F;
      send_cell(w, NW, "R4 near miss");
    end
    idle(2, 32'h1234_5678, "R4 idle");
  endtask

  task automatic t_misplaced;
    cell_t w;
    w = mk_cell(20, 1'b0);
    w[0] = 32'h48454C4C;
    w[1] = 32'h48454C4C;
    w[5] = 32'h48454C4C;
    w[6] = {8'h4F, 24'h000000};
    send_cell(w, NW, "R5 misplaced");
    idle(1, 32'h48454C4C, "R5 outside");
    idle(1, 32'h4F000000, "R5 outside");
    idle(3, 32'h0000_0000, "R5 outside");
  endtask

  task automatic t_back_to_back;
    for (int c = 0; c < 6; c++) begin
      send_cell(mk_cell(30 + c, c[0] == 1'b0), NW, "R6 back-to-back");
    end
    idle(2, 32'h0, "R6 idle");
  endtask

  task automatic t_abort;
    cell_t b;
    send_cell(mk_cell(40, 1'b1), 3, "R7 abort before word3");
    b = mk_cell(41, 1'b0);
    b[3][31:24] = 8'h4F;
    send_cell(b, NW, "R7 new cell");
    send_cell(mk_cell(42, 1'b1), 4, "R7 abort before word4");
    send_cell(mk_cell(43, 1'b1), NW, "R7 after abort");
    idle(3, 32'h0, "R7 idle");
  endtask

  task automatic t_room;
    for (int v = 0; v < 2; v++) begin
      tx_room = v[0];
      #1;
      check(rx_room == v[0], "R8 room pass", 32'(rx_room), 32'(v[0]));
    end
    tx_room = 1'b0;
    #1;
    check(rx_room == 1'b0, "R8 room pass", 32'(rx_room), 32'h0);
    tx_room = 1'b1;
  endtask

  initial begin
    total = 0;
    bad = 0;
    cyc = 0;
    finished = 1'b0;
    for (int i = 0; i < 256; i++) ex_v[i] = 1'b0;
    t_reset;
    t_match;
    t_near_miss;
    t_misplaced;
    t_back_to_back;
    t_abort;
    t_room;
    idle(3, 32'h0, "R2 drain");
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule